// File: doc/BRIEF.md
# Bank-Aware Prefetch Issue Arbiter

This block sits between a hardware prefetcher and the miss-tracking registers of one core. Prefetch candidates arrive already tagged with the DRAM bank they map to. Each candidate is queued in a small FIFO that belongs to its bank. Every cycle the block offers at most one queued prefetch downstream. It chooses the bank that currently has the fewest outstanding miss-register entries, so that the requests in flight spread over as many banks as possible.

A bank may only send a prefetch while its outstanding count does not exceed a send threshold. That threshold adapts to how useful recent prefetches turned out to be. An accuracy FSM runs in fixed windows. It counts prefetches issued and prefetches reported useful during each window. In the last cycle of a window it ranks the ratio into one of three levels, each with its own threshold (1, 7 or 27), and then starts a fresh window.

The accuracy FSM has two states:
- `WIN_RUN` counts cycles. Its transition `run_to_judge` fires in the second-to-last cycle of the window.
- `WIN_JUDGE` is a single cycle that loads the new threshold and restarts the counts. Its transition `judge_to_run` is unconditional.

Top module: `bank_spread_pf_arbiter`

## Requirements
- R1: After reset every bank FIFO is empty and every bank reports push ready. `iss_vld` is low, every occupancy counter is zero and the send threshold is 7.
- R2: A push is accepted when `pf_push_vld` is high and bit `pf_push_bank` of `pf_push_rdy` is high. Each bank issues its entries in the order they were pushed. That bank's ready bit is low while its FIFO holds `DEPTH` entries.
- R3: A bank's oldest entry is eligible only when the bank's FIFO is non-empty and its occupancy is less than or equal to the send threshold. `iss_vld` is high exactly when some bank is eligible.
- R4: Among eligible banks the one with the smallest occupancy is offered on `iss_bank`/`iss_addr`. A tie in occupancy goes to the lowest bank index.
- R5: An entry leaves its FIFO only in a cycle with `iss_vld` and `iss_rdy` both high. With `iss_rdy` low, nothing is removed.
- R6: A bank's occupancy rises by one on `alloc_vld` for that bank and falls by one on `free_vld` for that bank. It is unchanged when both events hit the same bank in one cycle. It saturates at 0 and at 2^OCC_W-1.
- R7: Windows last `INTERVAL` cycles, with the first window starting in the first cycle after reset. In the last cycle of a window, with U useful and I issued counted earlier in the window and I>0, the threshold becomes 1 if 5U < 2I, 27 if 20U >= 17I, and 7 otherwise. The new threshold takes effect from the next cycle.
- R8: A window in which no prefetch was issued leaves the threshold unchanged. The threshold changes at no other time.
- R9: The useful and issued counts restart at each window boundary. A useful pulse or an issue in the judging cycle counts toward the following window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_push_vld | input | 1 | Prefetcher offers a candidate |
| pf_push_bank | input | BANK_W | Bank of the offered candidate |
| pf_push_addr | input | AW | Address of the offered candidate |
| pf_push_rdy | output | NB | Per-bank ready; bit b low when bank b FIFO is full |
| iss_vld | output | 1 | A prefetch is offered downstream |
| iss_bank | output | BANK_W | Bank of the offered prefetch |
| iss_addr | output | AW | Address of the offered prefetch |
| iss_rdy | input | 1 | Miss registers accept the offer |
| alloc_vld | input | 1 | A miss-register entry was allocated |
| alloc_bank | input | BANK_W | Bank of the allocated entry |
| free_vld | input | 1 | A miss-register entry was released |
| free_bank | input | BANK_W | Bank of the released entry |
| useful_hit | input | 1 | A previously issued prefetch proved useful |

## Verification
On every cycle, the assertions check the following:
- the offered bank is eligible and no eligible bank has a smaller occupancy or an equal occupancy at a lower index;
- no FIFO is pushed while full or popped while empty, or popped without a handshake;
- an occupancy counter holds whenever its increment and decrement agree;
- the threshold moves only in a cycle that follows a judging cycle.

The specific threshold value chosen from the useful/issued ratio, the handling of a window with no issues, the per-bank ordering and the saturation points can only be shown by the bench's reference model. That model is driven through the accuracy bands, a drained idle period and a hot-bank flood.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    typedef enum logic [0:0] {
        WIN_RUN   = 1'b0,
        WIN_JUDGE = 1'b1
    } win_state_t;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_MID  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_KEEP = 2'd3
    } acc_level_t;

endpackage

// File: rtl/bsp_bank_fifo.sv
module bsp_bank_fifo #(
    parameter int AW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign head  = mem[rp_q];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            end
            if (pop) begin
                rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/bsp_occ_counter.sv
module bsp_occ_counter #(
    parameter int OCC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [OCC_W-1:0] occ
);
    localparam logic [OCC_W-1:0] OCC_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (occ != OCC_MAX) occ <= occ + 1'b1;
                2'b01:   if (occ != '0)      occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/bsp_acc_tracker.sv
module bsp_acc_tracker
    import bsp_pkg::*;
#(
    parameter int INTERVAL = 100000,
    parameter int OCC_W    = 6,
    parameter int THR_LO   = 1,
    parameter int THR_MID  = 7,
    parameter int THR_HI   = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             useful,
    input  logic             issued,
    output logic [OCC_W-1:0] thr
);
    localparam int CYC_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam int CNT_W = $clog2(INTERVAL + 1);
    localparam int PRD_W = CNT_W + 5;

    win_state_t     state_q, state_d;
    acc_level_t     level;
    logic [CYC_W-1:0] cyc_q;
    logic [CNT_W-1:0] use_cnt_q, iss_cnt_q;
    logic             judge;
    logic [PRD_W-1:0] use_x5, use_x20, iss_x2, iss_x17;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WIN_RUN;
        else        state_q <= state_d;
    end

    // transitions: run_to_judge, judge_to_run
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_RUN:   if (cyc_q == CYC_W'(INTERVAL - 2)) state_d = WIN_JUDGE;
            WIN_JUDGE: state_d = WIN_RUN;
            default:   state_d = WIN_RUN;
        endcase
    end

    // outputs of the FSM: judge strobe and accuracy level
    always_comb begin
        use_x5  = PRD_W'(use_cnt_q) * PRD_W'(5);
        use_x20 = PRD_W'(use_cnt_q) * PRD_W'(20);
        iss_x2  = PRD_W'(iss_cnt_q) * PRD_W'(2);
        iss_x17 = PRD_W'(iss_cnt_q) * PRD_W'(17);
        judge   = 1'b0;
        level   = LVL_KEEP;
        unique case (state_q)
            WIN_RUN: begin
                judge = 1'b0;
            end
            WIN_JUDGE: begin
                judge = 1'b1;
                if (iss_cnt_q == '0)        level = LVL_KEEP;
                else if (use_x5 < iss_x2)   level = LVL_LOW;
                else if (use_x20 >= iss_x17) level = LVL_HIGH;
                else                        level = LVL_MID;
            end
            default: judge = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q     <= '0;
            use_cnt_q <= '0;
            iss_cnt_q <= '0;
        end else if (judge) begin
            cyc_q     <= '0;
            use_cnt_q <= CNT_W'(useful);
            iss_cnt_q <= CNT_W'(issued);
        end else begin
            cyc_q     <= cyc_q + 1'b1;
            use_cnt_q <= use_cnt_q + CNT_W'(useful);
            iss_cnt_q <= iss_cnt_q + CNT_W'(issued);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr <= OCC_W'(THR_MID);
        end else begin
            unique case (level)
                LVL_LOW:  thr <= OCC_W'(THR_LO);
                LVL_MID:  thr <= OCC_W'(THR_MID);
                LVL_HIGH: thr <= OCC_W'(THR_HI);
                default:  thr <= thr;
            endcase
        end
    end
endmodule

// File: rtl/bsp_picker.sv
module bsp_picker #(
    parameter int NB     = 4,
    parameter int OCC_W  = 6,
    parameter int BANK_W = 2
) (
    input  logic [NB-1:0]            nonempty,
    input  logic [NB-1:0][OCC_W-1:0] occ,
    input  logic [OCC_W-1:0]         thr,
    output logic                     any,
    output logic [BANK_W-1:0]        sel
);
    logic [OCC_W-1:0] best;

    always_comb begin
        any  = 1'b0;
        sel  = '0;
        best = '1;
        for (int b = 0; b < NB; b++) begin
            if (nonempty[b] && (occ[b] <= thr) && (!any || (occ[b] < best))) begin
                any  = 1'b1;
                sel  = BANK_W'(b);
                best = occ[b];
            end
        end
    end
endmodule

// File: rtl/bank_spread_pf_arbiter.sv
module bank_spread_pf_arbiter #(
    parameter int NB       = 4,
    parameter int AW       = 16,
    parameter int DEPTH    = 4,
    parameter int OCC_W    = 6,
    parameter int INTERVAL = 100000,
    parameter int THR_LO   = 1,
    parameter int THR_MID  = 7,
    parameter int THR_HI   = 27,
    localparam int BANK_W  = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pf_push_vld,
    input  logic [BANK_W-1:0] pf_push_bank,
    input  logic [AW-1:0]     pf_push_addr,
    output logic [NB-1:0]     pf_push_rdy,
    output logic              iss_vld,
    output logic [BANK_W-1:0] iss_bank,
    output logic [AW-1:0]     iss_addr,
    input  logic              iss_rdy,
    input  logic              alloc_vld,
    input  logic [BANK_W-1:0] alloc_bank,
    input  logic              free_vld,
    input  logic [BANK_W-1:0] free_bank,
    input  logic              useful_hit
);
    logic [NB-1:0]            push_en, pop_en, empty, full, occ_inc, occ_dec;
    logic [NB-1:0][AW-1:0]    head;
    logic [NB-1:0][OCC_W-1:0] occ;
    logic [OCC_W-1:0]         thr;
    logic                     fire;

    assign fire     = iss_vld && iss_rdy;
    assign iss_addr = head[iss_bank];

    for (genvar g = 0; g < NB; g++) begin : g_bank
        assign pf_push_rdy[g] = !full[g];
        assign push_en[g] = pf_push_vld && (pf_push_bank == BANK_W'(g)) && !full[g];
        assign pop_en[g]  = fire && (iss_bank == BANK_W'(g));
        assign occ_inc[g] = alloc_vld && (alloc_bank == BANK_W'(g));
        assign occ_dec[g] = free_vld && (free_bank == BANK_W'(g));

        bsp_bank_fifo #(.AW(AW), .DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(push_en[g]), .push_data(pf_push_addr),
            .pop(pop_en[g]), .head(head[g]),
            .empty(empty[g]), .full(full[g])
        );

        bsp_occ_counter #(.OCC_W(OCC_W)) u_occ (
            .clk(clk), .rst_n(rst_n),
            .inc(occ_inc[g]), .dec(occ_dec[g]), .occ(occ[g])
        );
    end

    bsp_picker #(.NB(NB), .OCC_W(OCC_W), .BANK_W(BANK_W)) u_pick (
        .nonempty(~empty), .occ(occ), .thr(thr),
        .any(iss_vld), .sel(iss_bank)
    );

    bsp_acc_tracker #(
        .INTERVAL(INTERVAL), .OCC_W(OCC_W),
        .THR_LO(THR_LO), .THR_MID(THR_MID), .THR_HI(THR_HI)
    ) u_acc (
        .clk(clk), .rst_n(rst_n),
        .useful(useful_hit), .issued(fire), .thr(thr)
    );
endmodule

// File: rtl/bsp_arbiter_chk.sv
module bsp_arbiter_chk #(
    parameter int NB       = 4,
    parameter int OCC_W    = 6,
    parameter int INTERVAL = 100000,
    parameter int BANK_W   = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NB-1:0]            push_en,
    input logic [NB-1:0]            pop_en,
    input logic [NB-1:0]            empty,
    input logic [NB-1:0]            full,
    input logic [NB-1:0]            occ_inc,
    input logic [NB-1:0]            occ_dec,
    input logic [NB-1:0][OCC_W-1:0] occ,
    input logic [OCC_W-1:0]         thr,
    input logic                     iss_vld,
    input logic [BANK_W-1:0]        iss_bank,
    input logic                     iss_rdy
);
    localparam int PH_W = $clog2(INTERVAL + 1);
    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ph_q <= '0;
        else if (ph_q == PH_W'(INTERVAL - 1)) ph_q <= '0;
        else                                 ph_q <= ph_q + 1'b1;
    end

    // R3
    offer_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> (!empty[iss_bank] && (occ[iss_bank] <= thr)));

    // R8
    thr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != PH_W'(INTERVAL - 1)) |=> $stable(thr));

    for (genvar b = 0; b < NB; b++) begin : g_chk
        // R4
        least_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_vld && !empty[b] && (occ[b] <= thr)) |-> (occ[iss_bank] <= occ[b]));
        // R4
        tie_low_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_vld && !empty[b] && (occ[b] == occ[iss_bank])) |-> (iss_bank <= BANK_W'(b)));
        // R2
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            full[b] |-> !push_en[b]);
        // R5
        pop_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pop_en[b] |-> (iss_vld && iss_rdy && !empty[b]));
        // R6
        occ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (occ_inc[b] == occ_dec[b]) |=> $stable(occ[b]));
    end
endmodule

bind bank_spread_pf_arbiter bsp_arbiter_chk #(
    .NB(NB), .OCC_W(OCC_W), .INTERVAL(INTERVAL), .BANK_W(BANK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .pop_en(pop_en),
    .empty(empty), .full(full), .occ_inc(occ_inc), .occ_dec(occ_dec),
    .occ(occ), .thr(thr), .iss_vld(iss_vld), .iss_bank(iss_bank),
    .iss_rdy(iss_rdy)
);

// File: tb/sim_bank_spread_pf_arbiter.sv
`timescale 1ns/1ps
module sim_bank_spread_pf_arbiter;
    localparam int NB = 4, AW = 12, DEPTH = 4, OCC_W = 6, INTERVAL = 200;
    localparam int BW = 2;
    localparam int OCC_MAX = (1 << OCC_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pf_push_vld = 0, iss_rdy = 0, alloc_vld = 0, free_vld = 0, useful_hit = 0;
    logic [BW-1:0] pf_push_bank = 0, alloc_bank = 0, free_bank = 0;
    logic [AW-1:0] pf_push_addr = 0;
    logic [NB-1:0] pf_push_rdy;
    logic iss_vld;
    logic [BW-1:0] iss_bank;
    logic [AW-1:0] iss_addr;

    always #2.5 clk = ~clk;

    bank_spread_pf_arbiter #(.NB(NB), .AW(AW), .DEPTH(DEPTH), .OCC_W(OCC_W),
        .INTERVAL(INTERVAL)) u0 (
        .clk(clk), .rst_n(rst_n), .pf_push_vld(pf_push_vld), .pf_push_bank(pf_push_bank),
        .pf_push_addr(pf_push_addr), .pf_push_rdy(pf_push_rdy), .iss_vld(iss_vld),
        .iss_bank(iss_bank), .iss_addr(iss_addr), .iss_rdy(iss_rdy),
        .alloc_vld(alloc_vld), .alloc_bank(alloc_bank), .free_vld(free_vld),
        .free_bank(free_bank), .useful_hit(useful_hit));

    int n_chk = 0, n_bad = 0;
    logic [AW-1:0] mq [NB][$];
    int m_occ [NB];
    int m_thr, m_ph, m_use, m_iss;
    bit e_vld; int e_bank; logic [AW-1:0] e_addr; logic [NB-1:0] e_rdy;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void calc_exp();
        int best = 0;
        e_vld = 0; e_bank = 0; e_addr = '0;
        for (int b = 0; b < NB; b++) begin
            e_rdy[b] = (mq[b].size() < DEPTH);
            if (mq[b].size() > 0 && m_occ[b] <= m_thr && (!e_vld || m_occ[b] < best)) begin
                e_vld = 1; e_bank = b; best = m_occ[b];
            end
        end
        if (e_vld) e_addr = mq[e_bank][0];
    endfunction

    function automatic void step();
        bit fire = e_vld && iss_rdy;
        if (fire) void'(mq[e_bank].pop_front());
        if (pf_push_vld && e_rdy[pf_push_bank]) mq[pf_push_bank].push_back(pf_push_addr);
        for (int b = 0; b < NB; b++) begin
            bit inc = alloc_vld && alloc_bank == BW'(b);
            bit dec = free_vld && free_bank == BW'(b);
            if (inc && !dec && m_occ[b] < OCC_MAX) m_occ[b]++;
            if (dec && !inc && m_occ[b] > 0) m_occ[b]--;
        end
        if (m_ph == INTERVAL - 1) begin
            if (m_iss != 0) begin
                if (m_use * 5 < m_iss * 2)        m_thr = 1;
                else if (m_use * 20 >= m_iss * 17) m_thr = 27;
                else                               m_thr = 7;
            end
            m_use = int'(useful_hit); m_iss = int'(fire); m_ph = 0;
        end else begin
            m_use += int'(useful_hit); m_iss += int'(fire); m_ph++;
        end
    endfunction

    task automatic compare(string req);
        calc_exp();
        chk(pf_push_rdy == e_rdy, "R2", {req, " push_rdy"}, int'(pf_push_rdy), int'(e_rdy));
        chk(iss_vld == e_vld, "R3", {req, " iss_vld"}, int'(iss_vld), int'(e_vld));
        if (e_vld && iss_vld) begin
            chk(int'(iss_bank) == e_bank, "R4", {req, " iss_bank"}, int'(iss_bank), e_bank);
            chk(iss_addr == e_addr, "R2", {req, " iss_addr"}, int'(iss_addr), int'(e_addr));
        end
    endtask

    task automatic run(int n, string req, int p_push, int p_rdy, int p_alloc,
                       int p_free, int p_use, int hot);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pf_push_vld  = ($urandom % 100) < p_push;
            pf_push_bank = BW'($urandom % NB);
            pf_push_addr = AW'($urandom);
            iss_rdy      = ($urandom % 100) < p_rdy;
            alloc_vld    = ($urandom % 100) < p_alloc;
            alloc_bank   = (hot >= 0) ? BW'(hot) : BW'($urandom % NB);
            free_vld     = ($urandom % 100) < p_free;
            free_bank    = (hot >= 0) ? BW'(hot) : BW'($urandom % NB);
            useful_hit   = ($urandom % 100) < p_use;
            #1;
            compare(req);
            @(posedge clk);
            step();
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) m_occ[b] = 0;
        m_thr = 7; m_ph = 0; m_use = 0; m_iss = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        chk(iss_vld == 1'b0, "R1", "iss_vld after reset", int'(iss_vld), 0);
        chk(pf_push_rdy == '1, "R1", "push_rdy after reset", int'(pf_push_rdy), 15);
        calc_exp();
        @(posedge clk);
        step();
        run(300, "R2", 70, 30, 0, 0, 50, -1);
        run(200, "R5", 50, 5, 10, 10, 20, -1);
        run(400, "R4", 60, 70, 30, 30, 40, -1);
        run(120, "R6", 50, 80, 100, 0, 30, 2);
        run(150, "R6", 50, 80, 20, 100, 30, 2);
        run(600, "R7", 80, 100, 20, 20, 0, -1);
        run(400, "R3", 80, 100, 40, 20, 0, -1);
        run(600, "R7", 80, 100, 20, 20, 100, -1);
        run(500, "R8", 0, 100, 10, 10, 0, -1);
        run(800, "R9", 70, 90, 25, 25, 60, -1);
        run(400, "R3", 70, 90, 40, 30, 10, -1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule